// File: doc/BRIEF.md
# Folded Constant-Geometry Radix-2 FFT

This block computes an N-point discrete Fourier transform of complex fixed-point samples, with N = 2^K. It contains a single column of N/2 radix-2 butterflies. The column's wiring is the same for every stage, so the block loops that one column K times, once per clock, rather than building K separate stages. On each pass the column reads words j and j+N/2 of a working register array. It forms the half-sum and the half-difference, and multiplies the half-difference by a twiddle factor. It writes the two results back to words 2j and 2j+1. The twiddle depends on the stage and the butterfly position, and comes from a table computed from the parameters.

A transform runs in three phases. A one-cycle start pulse, given while the block is idle, opens a load phase of N cycles, and one sample is taken per cycle. K compute cycles follow. Then an unload phase of N cycles presents the results one per cycle in bit-reversed frequency order, and the last of these cycles carries a done flag. Each stage halves its outputs, so the results equal the DFT scaled by 1/N, and the word width stays constant.

Top module: `fft_fold`

## Requirements
- R1: While reset is held, and after it is released, the block is idle: idle_o=1, and load_o, out_valid_o and done_o are all 0.
- R2: When start_i=1 is seen in idle, load_o is high for exactly the next N cycles. The sample on in_re_i/in_im_i in the i-th of these cycles becomes input x[i].
- R3: After the last load cycle, exactly K compute cycles pass, with load_o and out_valid_o both low, before out_valid_o rises.
- R4: out_valid_o stays high for N consecutive cycles. During these cycles out_idx_o counts 0 to N-1, and done_o is 1 only in the cycle where out_idx_o=N-1.
- R5: The output at out_idx_o=p is X[f]/N, where f is p with its K bits reversed and X[f] = sum over t of x[t]*exp(-j*2*pi*f*t/N). Each component is within 3 LSB of the rounded exact value, for inputs of magnitude below 2^(W-2).
- R6: A twiddle with angle zero passes the data through exactly, and each stage floors the halved sum and difference. As a result, an impulse of amplitude A at x[0], with A a multiple of N, gives exactly A/N real and 0 imaginary on every output.
- R7: start_i is ignored outside idle. A start pulse during compute or unload neither restarts nor extends the transform, and load_o stays low after that transform finishes.
- R8: In the cycle after done_o, idle_o is 1, and a new start pulse given right away starts a correct new transform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts a transform when idle |
| in_re_i | input | W | Real part of the input sample |
| in_im_i | input | W | Imaginary part of the input sample |
| load_o | output | 1 | Sample on the inputs is taken this cycle |
| idle_o | output | 1 | Block is idle and can accept start_i |
| out_valid_o | output | 1 | Result on the outputs is valid |
| out_re_o | output | W | Real part of the result |
| out_im_o | output | W | Imaginary part of the result |
| out_idx_o | output | $clog2(N) | Position of the result in bit-reversed order |
| done_o | output | 1 | Last result of the transform |

## Verification
The impulse case makes every butterfly path depend on exact pass-through at angle zero and on the floor shift. A design that multiplied by a near-one twiddle, or that rounded the halving, would produce values one LSB off 1024 on some bins. Random inputs are compared bin by bin against a floating-point DFT read in bit-reversed order. A wrong twiddle exponent per stage, a missing shuffle, or natural-order output would put large errors on most bins. The bench counts the exact load and compute cycles, so an off-by-one in the phase counters shows up directly. Start pulses given during compute and during unload expose a controller that accepts start outside idle, because load_o would rise or the unload would restart.

// File: rtl/fft_pkg.sv
package fft_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOAD   = 2'd1,
    ST_RUN    = 2'd2,
    ST_UNLOAD = 2'd3
  } fft_state_e;
endpackage

// File: rtl/fft_ctrl.sv
module fft_ctrl
  import fft_pkg::*;
#(
  parameter int N = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  output fft_state_e           state_o,
  output logic [$clog2(N)-1:0] cnt_o
);
  localparam int K  = $clog2(N);
  localparam int CW = K;

  fft_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q + 1'b1;
    unique case (state_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (start_i) state_d = ST_LOAD;
      end
      ST_LOAD: if (cnt_q == CW'(N-1)) begin
        state_d = ST_RUN;
        cnt_d   = '0;
      end
      ST_RUN: if (cnt_q == CW'(K-1)) begin
        state_d = ST_UNLOAD;
        cnt_d   = '0;
      end
      ST_UNLOAD: if (cnt_q == CW'(N-1)) begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o = state_q;
  assign cnt_o   = cnt_q;

  AST_RUN_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && cnt_q == CW'(K-1)) |=> (state_q == ST_UNLOAD && cnt_q == '0)); // R3
endmodule

// File: rtl/fft_twiddle.sv
module fft_twiddle #(
  parameter int N = 8,
  parameter int W = 16
) (
  input  logic [$clog2(N)-2:0] exp_i,
  output logic signed [W-1:0]  w_re_o,
  output logic signed [W-1:0]  w_im_o
);
  localparam int  HALF  = N / 2;
  localparam real SCALE = (2.0 ** (W - 1)) - 1.0;
  localparam real PI    = 3.14159265358979323846;

  logic signed [W-1:0] tab_re [HALF];
  logic signed [W-1:0] tab_im [HALF];

  // exp(-j*2*pi*e/N) in Q1.(W-1)
  for (genvar e = 0; e < HALF; e++) begin : g_tab
    localparam real ANG = 2.0 * PI * real'(e) / real'(N);
    localparam real CR  = $cos(ANG) * SCALE;
    localparam real CI  = -$sin(ANG) * SCALE;
    localparam int  IR  = $rtoi(CR + ((CR >= 0.0) ? 0.5 : -0.5));
    localparam int  II  = $rtoi(CI + ((CI >= 0.0) ? 0.5 : -0.5));
    assign tab_re[e] = W'(IR);
    assign tab_im[e] = W'(II);
  end

  assign w_re_o = tab_re[exp_i];
  assign w_im_o = tab_im[exp_i];
endmodule

// File: rtl/fft_bfly.sv
module fft_bfly #(
  parameter int W = 16
) (
  input  logic signed [W-1:0] a_re_i,
  input  logic signed [W-1:0] a_im_i,
  input  logic signed [W-1:0] b_re_i,
  input  logic signed [W-1:0] b_im_i,
  input  logic signed [W-1:0] w_re_i,
  input  logic signed [W-1:0] w_im_i,
  input  logic                pass_i,
  output logic signed [W-1:0] s_re_o,
  output logic signed [W-1:0] s_im_o,
  output logic signed [W-1:0] d_re_o,
  output logic signed [W-1:0] d_im_o
);
  localparam int PW = 2 * W + 1;
  localparam logic signed [PW-1:0] RND  = {{(W+2){1'b0}}, 1'b1, {(W-2){1'b0}}};
  localparam logic signed [PW-1:0] MAXV = {{(W+2){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [PW-1:0] MINV = {{(W+2){1'b1}}, {(W-1){1'b0}}};

  logic signed [W:0]     sum_re, sum_im, dif_re, dif_im;
  logic signed [W-1:0]   h_re, h_im;
  logic signed [2*W-1:0] m_rr, m_ii, m_ri, m_ir;
  logic signed [PW-1:0]  p_re, p_im, r_re, r_im;

  // halve per stage with floor, width stays W
  assign sum_re = {a_re_i[W-1], a_re_i} + {b_re_i[W-1], b_re_i};
  assign sum_im = {a_im_i[W-1], a_im_i} + {b_im_i[W-1], b_im_i};
  assign dif_re = {a_re_i[W-1], a_re_i} - {b_re_i[W-1], b_re_i};
  assign dif_im = {a_im_i[W-1], a_im_i} - {b_im_i[W-1], b_im_i};

  assign s_re_o = W'(sum_re >>> 1);
  assign s_im_o = W'(sum_im >>> 1);
  assign h_re   = W'(dif_re >>> 1);
  assign h_im   = W'(dif_im >>> 1);

  assign m_rr = h_re * w_re_i;
  assign m_ii = h_im * w_im_i;
  assign m_ri = h_re * w_im_i;
  assign m_ir = h_im * w_re_i;

  assign p_re = {m_rr[2*W-1], m_rr} - {m_ii[2*W-1], m_ii};
  assign p_im = {m_ri[2*W-1], m_ri} + {m_ir[2*W-1], m_ir};
  assign r_re = (p_re + RND) >>> (W - 1);
  assign r_im = (p_im + RND) >>> (W - 1);

  always_comb begin
    if (pass_i) begin
      d_re_o = h_re;
      d_im_o = h_im;
    end else begin
      d_re_o = (r_re > MAXV) ? MAXV[W-1:0] : (r_re < MINV) ? MINV[W-1:0] : W'(r_re);
      d_im_o = (r_im > MAXV) ? MAXV[W-1:0] : (r_im < MINV) ? MINV[W-1:0] : W'(r_im);
    end
  end
endmodule

// File: rtl/fft_fold.sv
module fft_fold
  import fft_pkg::*;
#(
  parameter int N = 8,
  parameter int W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [W-1:0]         in_re_i,
  input  logic [W-1:0]         in_im_i,
  output logic                 load_o,
  output logic                 idle_o,
  output logic                 out_valid_o,
  output logic [W-1:0]         out_re_o,
  output logic [W-1:0]         out_im_o,
  output logic [$clog2(N)-1:0] out_idx_o,
  output logic                 done_o
);
  localparam int K    = $clog2(N);
  localparam int CW   = K;
  localparam int HALF = N / 2;
  localparam int HW   = K - 1;

  fft_state_e    state;
  logic [CW-1:0] cnt;

  logic signed [W-1:0] x_re [N];
  logic signed [W-1:0] x_im [N];
  logic signed [W-1:0] c_re [N];
  logic signed [W-1:0] c_im [N];

  fft_ctrl #(.N(N)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .state_o (state),
    .cnt_o   (cnt)
  );

  // one stage column: read j, j+N/2; write 2j, 2j+1
  for (genvar j = 0; j < HALF; j++) begin : g_col
    logic [HW-1:0]       jv, ex;
    logic signed [W-1:0] w_re, w_im;
    assign jv = HW'(j);
    assign ex = (jv >> cnt) << cnt;

    fft_twiddle #(.N(N), .W(W)) u_tw (
      .exp_i  (ex),
      .w_re_o (w_re),
      .w_im_o (w_im)
    );

    fft_bfly #(.W(W)) u_bf (
      .a_re_i (x_re[j]),
      .a_im_i (x_im[j]),
      .b_re_i (x_re[j+HALF]),
      .b_im_i (x_im[j+HALF]),
      .w_re_i (w_re),
      .w_im_i (w_im),
      .pass_i (ex == '0),
      .s_re_o (c_re[2*j]),
      .s_im_o (c_im[2*j]),
      .d_re_o (c_re[2*j+1]),
      .d_im_o (c_im[2*j+1])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) begin
        x_re[i] <= '0;
        x_im[i] <= '0;
      end
    end else if (state == ST_LOAD) begin
      x_re[cnt] <= in_re_i;
      x_im[cnt] <= in_im_i;
    end else if (state == ST_RUN) begin
      for (int i = 0; i < N; i++) begin
        x_re[i] <= c_re[i];
        x_im[i] <= c_im[i];
      end
    end
  end

  assign load_o      = (state == ST_LOAD);
  assign idle_o      = (state == ST_IDLE);
  assign out_valid_o = (state == ST_UNLOAD);
  assign out_idx_o   = out_valid_o ? cnt : '0;
  assign out_re_o    = out_valid_o ? x_re[cnt] : '0;
  assign out_im_o    = out_valid_o ? x_im[cnt] : '0;
  assign done_o      = out_valid_o && (cnt == CW'(N-1));

  AST_LOAD_FROM_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(load_o) |-> ($past(start_i) && $past(idle_o))); // R2
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle_o && start_i) |=> (!load_o || $past(load_o))); // R7
  AST_IDX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !done_o) |=> (out_valid_o && out_idx_o == $past(out_idx_o) + 1'b1)); // R4
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (idle_o && !out_valid_o)); // R8
endmodule

// File: tb/fft_fold_bench.sv
module fft_fold_bench;
  localparam int N   = 8;
  localparam int W   = 16;
  localparam int K   = $clog2(N);
  localparam int TOL = 3;
  localparam real PI = 3.14159265358979323846;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] in_re = '0, in_im = '0;
  logic         load_o, idle_o, out_valid_o, done_o;
  logic [W-1:0] out_re_o, out_im_o;
  logic [K-1:0] out_idx_o;

  int total = 0, bad = 0;
  bit finished = 0;
  int xr [N], xi [N], gr [N], gi [N];

  always #4 clk = ~clk;

  fft_fold #(.N(N), .W(W)) u_fft_fold (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .in_re_i(in_re), .in_im_i(in_im),
    .load_o(load_o), .idle_o(idle_o), .out_valid_o(out_valid_o),
    .out_re_o(out_re_o), .out_im_o(out_im_o), .out_idx_o(out_idx_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int brev(input int p);
    int r = 0;
    for (int b = 0; b < K; b++) if (p[b]) r |= 1 << (K - 1 - b);
    return r;
  endfunction

  function automatic int rnd(input real v);
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
  endfunction

  function automatic int abs_i(input int v);
    return (v < 0) ? -v : v;
  endfunction

  // poke: raise start during compute and unload
  task automatic run_fft(input bit poke);
    int loads = 0, gap = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (load_o) loads++;
      in_re = W'(xr[i]); in_im = W'(xi[i]);
      @(negedge clk);
    end
    chk(loads == N, "R2 load cycles", loads, N);
    while (!out_valid_o && gap < 50) begin
      chk(!load_o, "R3 load low in compute", int'(load_o), 0);
      if (poke) start = 1'b1;
      gap++;
      @(negedge clk);
    end
    start = 1'b0;
    chk(gap == K, "R3 compute cycles", gap, K);
    for (int p = 0; p < N; p++) begin
      chk(out_valid_o, "R4 valid", int'(out_valid_o), 1);
      chk(int'(out_idx_o) == p, "R4 index", int'(out_idx_o), p);
      chk(done_o == (p == N - 1), "R4 done", int'(done_o), int'(p == N - 1));
      gr[p] = int'($signed(out_re_o));
      gi[p] = int'($signed(out_im_o));
      start = (poke && p == 2);
      @(negedge clk);
    end
    start = 1'b0;
    chk(idle_o && !out_valid_o, "R8 idle after done", int'(idle_o), 1);
  endtask

  task automatic check_dft(input string req);
    for (int p = 0; p < N; p++) begin
      int f = brev(p);
      real sr = 0.0, si = 0.0;
      for (int t = 0; t < N; t++) begin
        real th = 2.0 * PI * real'(f * t) / real'(N);
        sr += real'(xr[t]) * $cos(th) + real'(xi[t]) * $sin(th);
        si += real'(xi[t]) * $cos(th) - real'(xr[t]) * $sin(th);
      end
      chk(abs_i(gr[p] - rnd(sr / N)) <= TOL, req, gr[p], rnd(sr / N));
      chk(abs_i(gi[p] - rnd(si / N)) <= TOL, req, gi[p], rnd(si / N));
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    #3;
    chk(idle_o && !load_o && !out_valid_o && !done_o, "R1 in reset", int'(idle_o), 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(idle_o, "R1 idle", int'(idle_o), 1);
    chk(!load_o && !out_valid_o && !done_o, "R1 outputs low", int'(load_o | out_valid_o | done_o), 0);

    // R6 impulse exact
    for (int i = 0; i < N; i++) begin xr[i] = 0; xi[i] = 0; end
    xr[0] = 8192;
    run_fft(1'b0);
    for (int p = 0; p < N; p++) begin
      chk(gr[p] == 8192 / N, "R6 impulse re", gr[p], 8192 / N);
      chk(gi[p] == 0, "R6 impulse im", gi[p], 0);
    end

    // R5 shifted impulse and constant
    for (int i = 0; i < N; i++) begin xr[i] = 0; xi[i] = 0; end
    xi[1] = -7000;
    run_fft(1'b0);
    check_dft("R5 impulse at 1");
    for (int i = 0; i < N; i++) begin xr[i] = 4000; xi[i] = -3000; end
    run_fft(1'b0);
    check_dft("R5 constant");

    // R5 random, back to back (R8)
    for (int n = 0; n < 6; n++) begin
      for (int i = 0; i < N; i++) begin
        xr[i] = int'($urandom_range(16382)) - 8191;
        xi[i] = int'($urandom_range(16382)) - 8191;
      end
      run_fft(1'b0);
      check_dft("R5 random R8 back to back");
    end

    // R7 start during compute and unload
    for (int i = 0; i < N; i++) begin
      xr[i] = int'($urandom_range(16382)) - 8191;
      xi[i] = int'($urandom_range(16382)) - 8191;
    end
    run_fft(1'b1);
    check_dft("R7 result with stray start");
    for (int c = 0; c < 4; c++) begin
      chk(!load_o && idle_o, "R7 no restart", int'(load_o), 0);
      @(negedge clk);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule